// File: doc/BRIEF.md
# Entropy accumulation shift register

This block folds raw entropy into a long linear feedback shift register. A set of source sample bits arrives beside a per-source enable mask. On each sample strobe the register moves one place toward its most significant end. Its new least significant bit is the XNOR of the two tap bits, XORed with the parity of all enabled source bits. A sequencer that owns the sampling policy asks for a 64-bit result with a one-cycle request. It receives the low 64 bits of the register one cycle later, and accumulation carries on without any pause.

For seeding and test, a test-mode input first clears the register. After that the register can be read and written as three words: two 32-bit words and a top word that holds the remaining bits. In test mode only, a feedback-bypass request turns the register into a plain shift register. In that mode it takes in only the source parity, and it shifts on every cycle whether or not a strobe is present. Outside test mode the word port reads as zero and ignores writes.

Top module: `erg_accum`

## Requirements
- R1: While and after the synchronous active-high reset, the register is zero, the test-mode access is closed, `rd_data` is 0, `result_vld` is 0 and `result_data` is 0.
- R2: On a clock edge with `sample_stb` high and no bypass, the register S (81 bits) becomes {S[79:0], b}. Here b = ~(S[80] ^ S[76]) ^ p, and p is the XOR of all bits of `src_bits & src_en`.
- R3: On an edge with no strobe, no active bypass, no accepted write and no test-mode entry, the register keeps its value.
- R4: A source whose `src_en` bit is 0 has no effect on the shifted-in bit.
- R5: On the first edge where `test_mode` is seen high after being low, the register is cleared to zero. This clear takes precedence over writes and shifts in that cycle. Word access opens from the next cycle.
- R6: `rd_data` is registered, with one cycle of latency. When access is open, `rd_sel` 0 returns S[31:0], 1 returns S[63:32], 2 returns S[80:64] zero-extended, and 3 returns 0. When access is closed it returns 0.
- R7: With access open, `wr_en` with `wr_sel` 0, 1 or 2 loads that word from `wr_data`, using the low 17 bits for word 2. The load leaves the other words unchanged and overrides a shift in the same cycle. With access closed, writes have no effect.
- R8: `no_fb_req` acts only while access is open. It then shifts {S[79:0], p} on every edge, regardless of `sample_stb`. Outside test mode it has no effect.
- R9: `result_req` high at an edge yields `result_vld` high for one cycle after that edge, with `result_data` equal to S[63:0] as it was before that edge. The register keeps running.
- R10: The all-ones state is the lockup state: with feedback active and p = 0, a strobe keeps the register all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Sample strobe: shift one step |
| src_bits | input | 24 | Raw source sample bits |
| src_en | input | 24 | Per-source enable mask |
| test_mode | input | 1 | Test mode request (clears on entry, opens word access) |
| no_fb_req | input | 1 | Feedback bypass request, honoured in test mode only |
| wr_en | input | 1 | Word write strobe |
| wr_sel | input | 2 | Word select for writes (0 low, 1 middle, 2 top) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Word select for reads |
| rd_data | output | 32 | Registered read data |
| result_req | input | 1 | Request a 64-bit result |
| result_data | output | 64 | Captured low 64 bits |
| result_vld | output | 1 | Result valid, one cycle after request |

## Verification
A wrong tap, a wrong feedback polarity or a badly mixed source bit corrupts one bit of the register. That bit shows up in the result word on the next request, or in a test-mode read one cycle later, and it keeps shifting upward on every later strobe, so the fault never goes away. The bench keeps a reference copy of the register that it computes from the requirements. It compares that copy with every read and every result over long random stretches, both inside and outside test mode. Directed cases cover the entry clear, write precedence, the lockup state, masked sources and a bypass request outside test mode.

// File: rtl/erg_pkg.sv
package erg_pkg;
  localparam int WORD_W = 32;
  localparam int RES_W  = 64;
  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_MID  = 2'd1;
  localparam logic [1:0] SEL_TOP  = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;
endpackage

// File: rtl/erg_lfsr_core.sv
module erg_lfsr_core
  import erg_pkg::*;
#(
  parameter int           W    = 81,
  parameter int           NSRC = 24,
  parameter logic [W-1:0] TAPS = (W'(1) << (W-1)) | (W'(1) << (W-5))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [NSRC-1:0]   src_bits,
  input  logic [NSRC-1:0]   src_en,
  input  logic              test_mode,
  input  logic              no_fb_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [W-1:0]      state_o,
  output logic              test_active_o
);
  localparam int TOP_W = W - 2*WORD_W;

  logic [W-1:0] state_q, state_d;
  logic         tm_q;
  logic         ent, fb, nofb_eff, step, shin, entering, wr_hit;

  // parity of enabled sources, XNOR feedback over the tap mask
  assign ent      = ^(src_bits & src_en);
  assign fb       = ~(^(state_q & TAPS));
  assign nofb_eff = no_fb_req & tm_q;
  assign step     = sample_stb | nofb_eff;
  assign shin     = nofb_eff ? ent : (fb ^ ent);
  assign entering = test_mode & ~tm_q;
  assign wr_hit   = wr_en & tm_q & (wr_sel != SEL_NONE);

  always_comb begin
    state_d = state_q;
    if (wr_hit) begin
      case (wr_sel)
        SEL_LO:  state_d[WORD_W-1:0]        = wr_data;
        SEL_MID: state_d[2*WORD_W-1:WORD_W] = wr_data;
        default: state_d[W-1:2*WORD_W]      = wr_data[TOP_W-1:0];
      endcase
    end else if (step) begin
      state_d = {state_q[W-2:0], shin};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      tm_q    <= 1'b0;
    end else begin
      tm_q    <= test_mode;
      state_q <= entering ? '0 : state_d;
    end
  end

  assign state_o       = state_q;
  assign test_active_o = tm_q;

  // R5: entering test mode clears the register
  a_r5_entry_clears: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !tm_q) |=> (state_q == '0));

  // R3: idle cycle keeps the register
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!sample_stb && !nofb_eff && !wr_hit && !entering) |=> $stable(state_q));

  // R8: bypass shifts in only the source parity
  a_r8_plain_shift: assert property (@(posedge clk) disable iff (rst)
    (nofb_eff && !wr_hit && !entering) |=>
      (state_q == {$past(state_q[W-2:0]), $past(ent)}));

  // R10: all-ones is the lockup state with feedback and zero parity
  a_r10_lockup: assert property (@(posedge clk) disable iff (rst)
    ((&state_q) && sample_stb && !nofb_eff && !wr_hit && !entering && !ent)
      |=> (&state_q));
endmodule

// File: rtl/erg_word_port.sv
module erg_word_port
  import erg_pkg::*;
#(
  parameter int W = 81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_active,
  input  logic [1:0]        rd_sel,
  input  logic [W-1:0]      state,
  output logic [WORD_W-1:0] rd_data
);
  localparam int TOP_W = W - 2*WORD_W;

  logic [WORD_W-1:0] words [3];
  logic [WORD_W-1:0] mux;

  generate
    if (TOP_W == WORD_W) begin : g_full_top
      assign words[2] = state[W-1:2*WORD_W];
    end else begin : g_pad_top
      assign words[2] = {{(WORD_W-TOP_W){1'b0}}, state[W-1:2*WORD_W]};
    end
  endgenerate
  assign words[0] = state[WORD_W-1:0];
  assign words[1] = state[2*WORD_W-1:WORD_W];

  always_comb begin
    mux = '0;
    if (test_active && rd_sel != SEL_NONE) mux = words[rd_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux;
  end

  // R6: access closed reads zero
  a_r6_blocked: assert property (@(posedge clk) disable iff (rst)
    !test_active |=> (rd_data == '0));
endmodule

// File: rtl/erg_result_reg.sv
module erg_result_reg
  import erg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [RES_W-1:0] low_bits,
  output logic [RES_W-1:0] data,
  output logic             vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= req;
      if (req) data <= low_bits;
    end
  end

  // R9: request yields the prior low bits one cycle later
  a_r9_capture: assert property (@(posedge clk) disable iff (rst)
    req |=> (vld && data == $past(low_bits)));
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    !req |=> !vld);
endmodule

// File: rtl/erg_accum.sv
module erg_accum
  import erg_pkg::*;
#(
  parameter int W    = 81,
  parameter int NSRC = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [NSRC-1:0]   src_bits,
  input  logic [NSRC-1:0]   src_en,
  input  logic              test_mode,
  input  logic              no_fb_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              result_req,
  output logic [RES_W-1:0]  result_data,
  output logic              result_vld
);
  logic [W-1:0] state;
  logic         test_active;

  erg_lfsr_core #(.W(W), .NSRC(NSRC)) u_core (
    .clk(clk), .rst(rst), .sample_stb(sample_stb),
    .src_bits(src_bits), .src_en(src_en),
    .test_mode(test_mode), .no_fb_req(no_fb_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .state_o(state), .test_active_o(test_active)
  );

  erg_word_port #(.W(W)) u_port (
    .clk(clk), .rst(rst), .test_active(test_active),
    .rd_sel(rd_sel), .state(state), .rd_data(rd_data)
  );

  erg_result_reg u_res (
    .clk(clk), .rst(rst), .req(result_req),
    .low_bits(state[RES_W-1:0]), .data(result_data), .vld(result_vld)
  );
endmodule

// File: tb/tb_erg_accum.sv
module tb_erg_accum;
  localparam int W    = 81;
  localparam int NSRC = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            d_stb = 0, d_tm = 0, d_nofb = 0, d_wr = 0, d_req = 0;
  logic [NSRC-1:0] d_src = '0, d_en = '0;
  logic [1:0]      d_wsel = '0, d_rsel = '0;
  logic [31:0]     d_wdata = '0;
  logic [31:0]     rd_data;
  logic [63:0]     result_data;
  logic            result_vld;

  erg_accum #(.W(W), .NSRC(NSRC)) dut (
    .clk(clk), .rst(rst), .sample_stb(d_stb), .src_bits(d_src), .src_en(d_en),
    .test_mode(d_tm), .no_fb_req(d_nofb), .wr_en(d_wr), .wr_sel(d_wsel),
    .wr_data(d_wdata), .rd_sel(d_rsel), .rd_data(rd_data),
    .result_req(d_req), .result_data(result_data), .result_vld(result_vld)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] st_m = '0;
  logic         tm_m = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [W-1:0] s, input logic [1:0] sel);
    case (sel)
      2'd0: return s[31:0];
      2'd1: return s[63:32];
      2'd2: return {15'b0, s[80:64]};
      default: return 32'h0;
    endcase
  endfunction

  // one clock: model update from requirements, then compare at negedge
  task automatic tick(input bit chk_rd, input string tag_rd, input bit chk_res, input string tag_res);
    logic [W-1:0] old;
    logic [31:0]  exp_rd;
    logic         p;
    bit           byp;
    old    = st_m;
    exp_rd = tm_m ? word_of(old, d_rsel) : 32'h0;
    p      = ^(d_src & d_en);
    byp    = d_nofb && tm_m;
    if (d_tm && !tm_m) st_m = '0;
    else if (tm_m && d_wr && d_wsel != 2'd3) begin
      case (d_wsel)
        2'd0: st_m[31:0]  = d_wdata;
        2'd1: st_m[63:32] = d_wdata;
        default: st_m[80:64] = d_wdata[16:0];
      endcase
    end else if (d_stb || byp)
      st_m = {old[W-2:0], byp ? p : (~(old[80] ^ old[76]) ^ p)};
    tm_m = d_tm;
    @(posedge clk);
    @(negedge clk);
    if (chk_rd) chk(rd_data == exp_rd, tag_rd, 64'(rd_data), 64'(exp_rd));
    if (chk_res) begin
      chk(result_vld == d_req, {tag_res, " valid"}, 64'(result_vld), 64'(d_req));
      if (d_req) chk(result_data == old[63:0], tag_res, result_data, old[63:0]);
    end
  endtask

  task automatic quiet();
    d_stb = 0; d_nofb = 0; d_wr = 0; d_req = 0;
  endtask

  task automatic randomize_inputs(input bit allow_nofb);
    d_stb   = 1'($urandom());
    d_src   = NSRC'($urandom());
    d_en    = NSRC'($urandom());
    d_nofb  = allow_nofb ? ($urandom_range(0, 3) == 0) : 1'b0;
    d_wr    = ($urandom_range(0, 3) == 0);
    d_wsel  = 2'($urandom());
    d_wdata = $urandom();
    d_rsel  = 2'($urandom());
    d_req   = ($urandom_range(0, 5) == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd_data == 0, "R1 rd_data", 64'(rd_data), 0);
    chk(result_vld == 0, "R1 result_vld", 64'(result_vld), 0);
    chk(result_data == 0, "R1 result_data", result_data, 0);
    d_req = 1; tick(1, "R1 rd", 1, "R1 zero result");
    quiet();

    // R2 directed strobes from zero with all sources enabled
    d_en = '1;
    for (int i = 0; i < 8; i++) begin
      d_stb = 1; d_src = NSRC'(i * 32'h1357);
      tick(0, "", 0, "");
    end
    d_stb = 0; d_req = 1; tick(0, "", 1, "R2 strobe shift");
    d_req = 0;

    // R3 no strobe: result stable over several idle cycles
    repeat (4) tick(0, "", 0, "");
    d_req = 1; tick(0, "", 1, "R3 hold");
    d_req = 0;

    // R4 masked sources: all bits high but disabled
    d_src = '1; d_en = '0; d_stb = 1; tick(0, "", 0, "");
    d_stb = 0; d_req = 1; tick(0, "", 1, "R4 masked sources");
    d_req = 0;

    // R6/R7/R8 outside test mode: reads zero, writes and bypass ignored
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs(1);
      tick(1, "R6 closed read", 1, "R8 R7 closed port");
    end
    quiet();

    // R5 entry clears
    d_tm = 1; tick(0, "", 0, "");
    for (int s = 0; s < 3; s++) begin
      d_rsel = 2'(s); tick(1, "R5 cleared word", 0, "");
      chk(rd_data == 0, "R5 cleared literal", 64'(rd_data), 0);
    end

    // R7 write beats a shift in the same cycle
    d_wr = 1; d_wsel = 0; d_wdata = 32'hA5A5_A5A5; d_stb = 1; tick(0, "", 0, "");
    quiet(); d_rsel = 0; tick(1, "R7 precedence", 0, "");
    chk(rd_data == 32'hA5A5_A5A5, "R7 precedence literal", 64'(rd_data), 64'hA5A5_A5A5);
    d_wr = 1; d_wsel = 2; d_wdata = 32'hFFFF_FFFF; tick(0, "", 0, "");
    quiet(); d_rsel = 2; tick(1, "R6 top word", 0, "");
    chk(rd_data == 32'h0001_FFFF, "R6 top zero-extend", 64'(rd_data), 64'h1FFFF);
    d_rsel = 3; tick(1, "R6 select three", 0, "");

    // R10 lockup
    for (int s = 0; s < 3; s++) begin
      d_wr = 1; d_wsel = 2'(s); d_wdata = 32'hFFFF_FFFF; tick(0, "", 0, "");
    end
    quiet(); d_en = '0; d_stb = 1;
    repeat (5) tick(0, "", 0, "");
    d_stb = 0;
    for (int s = 0; s < 3; s++) begin
      d_rsel = 2'(s); tick(1, "R10 lockup", 0, "");
      chk(rd_data == (s == 2 ? 32'h1FFFF : 32'hFFFF_FFFF), "R10 lockup literal",
          64'(rd_data), (s == 2 ? 64'h1FFFF : 64'hFFFF_FFFF));
    end

    // R8 bypass in test mode, every cycle, strobe irrelevant
    for (int i = 0; i < 500; i++) begin
      randomize_inputs(0);
      d_nofb = 1; d_wr = 0;
      tick(1, "R8 bypass read", 1, "R8 bypass result");
    end

    // R2 R6 R7 R9 mixed test-mode traffic
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs(1);
      tick(1, "R7 R6 test read", 1, "R9 test result");
    end

    // leave test mode: R6 closed again, R9 results keep running with R2 feedback
    quiet(); d_tm = 0; tick(0, "", 0, "");
    for (int i = 0; i < 2000; i++) begin
      randomize_inputs(0);
      tick(1, "R6 closed after exit", 1, "R9 R2 running");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule